// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This unit takes two 32-bit single-precision operands and returns their product in the same format. It also returns an overflow flag and an underflow flag. A caller presents both operands with a one-cycle `in_valid` strobe. After a fixed delay, a registered result appears together with a one-cycle `out_valid` pulse. The result and its flags then stay unchanged until the next pulse. NaN and infinity inputs are not handled, and the only rounding is truncation.

Internally the unit is a three-state controller that drives a shift-add significand datapath:

- **IDLE** waits for `in_valid`. When the strobe arrives (transition *accept*), it captures the operand fields, loads the datapath and moves to MUL.
- **MUL** adds one multiplier bit per cycle for 24 cycles. The *last_bit* transition then moves to PACK.
- **PACK** normalises the product, forms the exponent, applies the zero, overflow and underflow rules, and registers the outputs. The *emit* transition returns to IDLE.

Strobes that arrive while the unit is in MUL or PACK are dropped.

Top module: `fmul_core`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `ovf`, `unf` and `result` are all 0.
- R2: `out_valid` is a single-cycle pulse. It is high in the 25th cycle after the clock edge that accepted `in_valid`, which is FRAC_W+2 cycles.
- R3: For a nonzero result, the result sign (bit 31) is the XOR of the two operand signs. This includes the overflow and underflow cases.
- R4: If either operand has an exponent field (bits 30:23) of 0, the result word is 0x00000000 and both flags are 0.
- R5: The two 24-bit significands, each with its hidden 1, are multiplied exactly into a 48-bit product. The 23-bit fraction (bits 22:0) is taken from the 23 product bits just below the leading one, and the lower bits are discarded with no rounding. For example, 0xC1900000 × 0x41180000 gives 0xC32B0000.
- R6: When the product is 2 or more (top product bit set), the fraction is taken one place higher and the exponent is increased by 1. For example, 0x3FC00000 × 0x3FC00000 gives 0x40100000.
- R7: The unbounded exponent is e = ea + eb − 127 + n, where n is 1 when the R6 shift occurs and 0 otherwise. When 1 ≤ e ≤ 254, e is the exponent field of the result.
- R8: If e ≥ 255, the result is signed infinity (exponent field 255, fraction 0) and `ovf` = 1, `unf` = 0.
- R9: If e ≤ 0, the exponent and fraction fields are 0, the sign is kept, and `unf` = 1, `ovf` = 0.
- R10: An `in_valid` strobe seen while an operation is in progress is ignored. The pending result is unchanged and no extra `out_valid` pulse follows.
- R11: Between `out_valid` pulses, `result`, `ovf` and `unf` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe, sampled in IDLE only |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Product word |
| ovf | output | 1 | Exponent overflow, result saturated to infinity |
| unf | output | 1 | Exponent underflow, result flushed to signed zero |

## Verification
Normalisation and the exponent range limits can act on the same result in one PACK cycle. In that cycle, the extra +1 from a product of 2 or more decides whether the result saturates or is flushed. The sweep crosses exponent pairs whose unadjusted sum lands at 254 and at 0 with fractions that do and do not carry into the top product bit. For example, 190 + 191 with 1.5 × 1.5 overflows, while the same pair with 1.0 × 1.0 does not. Likewise, 63 + 64 with 1.5 × 1.5 survives as exponent 1, while with 1.0 × 1.0 it underflows. Each outcome is judged against a product the bench forms with a plain integer multiply and the exponent rule written out arithmetically.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MUL  = 2'd1,
        S_PACK = 2'd2
    } fmul_state_t;
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [SIG_W-1:0]  sig,
    output logic              is_zero
);
    assign sign    = word[WORD_W-1];
    assign expo    = word[WORD_W-2 -: EXP_W];
    assign sig     = {1'b1, word[FRAC_W-1:0]};
    assign is_zero = (word[WORD_W-2 -: EXP_W] == '0);
endmodule

// File: rtl/fmul_shiftadd.sv
module fmul_shiftadd #(
    parameter int SIG_W = 24,
    localparam int PROD_W = 2 * SIG_W,
    localparam int HI_W   = SIG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SIG_W-1:0] mcand,
    input  logic [SIG_W-1:0] mplier,
    output logic [HI_W-1:0]  prod_hi
);
    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] mc;
    logic [SIG_W-1:0]  mp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            mc  <= '0;
            mp  <= '0;
        end else if (load) begin
            acc <= '0;
            mc  <= {{SIG_W{1'b0}}, mcand};
            mp  <= mplier;
        end else if (step) begin
            if (mp[0]) acc <= acc + mc;
            mc <= mc << 1;
            mp <= mp >> 1;
        end
    end

    assign prod_hi = acc[PROD_W-1 -: HI_W];
endmodule

// File: rtl/fmul_pack.sv
module fmul_pack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int HI_W   = FRAC_W + 2,
    localparam int XW     = EXP_W + 2,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
    localparam int EMAX   = (1 << EXP_W) - 1
) (
    input  logic [HI_W-1:0]   prod_hi,
    input  logic [EXP_W-1:0]  ea,
    input  logic [EXP_W-1:0]  eb,
    input  logic              sign,
    input  logic              zero,
    output logic [WORD_W-1:0] word,
    output logic              ovf,
    output logic              unf
);
    logic                    carry;
    logic [FRAC_W-1:0]       frac;
    logic signed [XW-1:0]    e_sum;

    assign carry = prod_hi[HI_W-1];
    assign frac  = carry ? prod_hi[HI_W-2:1] : prod_hi[HI_W-3:0];
    assign e_sum = $signed({2'b00, ea}) + $signed({2'b00, eb})
                 - $signed(XW'(BIAS)) + $signed({{(XW-1){1'b0}}, carry});

    always_comb begin
        ovf  = 1'b0;
        unf  = 1'b0;
        word = {sign, e_sum[EXP_W-1:0], frac};
        if (zero) begin
            word = '0;
        end else if (e_sum >= $signed(XW'(EMAX))) begin
            ovf  = 1'b1;
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e_sum <= $signed(XW'(0))) begin
            unf  = 1'b1;
            word = {sign, {(WORD_W-1){1'b0}}};
        end
    end
endmodule

// File: rtl/fmul_core.sv
module fmul_core #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int HI_W   = SIG_W + 1,
    localparam int CNT_W  = $clog2(SIG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf
);
    import fmul_pkg::*;

    fmul_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;

    logic [1:0]             u_sign;
    logic [1:0]             u_zero;
    logic [EXP_W-1:0]       u_exp [2];
    logic [SIG_W-1:0]       u_sig [2];
    logic [WORD_W-1:0]      u_word [2];

    assign u_word[0] = op_a;
    assign u_word[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
            .word    (u_word[i]),
            .sign    (u_sign[i]),
            .expo    (u_exp[i]),
            .sig     (u_sig[i]),
            .is_zero (u_zero[i])
        );
    end

    logic             sign_r, zero_r;
    logic [EXP_W-1:0] ea_r, eb_r;
    logic             accept, last_bit;
    logic [HI_W-1:0]  prod_hi;
    logic [WORD_W-1:0] pk_word;
    logic             pk_ovf, pk_unf;

    assign accept   = (state == S_IDLE) && in_valid;
    assign last_bit = (state == S_MUL) && (cnt == CNT_W'(SIG_W - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept)   state_nx = S_MUL;
            S_MUL:   if (last_bit) state_nx = S_PACK;
            S_PACK:                state_nx = S_IDLE;
            default:               state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sign_r <= 1'b0;
            zero_r <= 1'b0;
            ea_r   <= '0;
            eb_r   <= '0;
        end else if (accept) begin
            cnt    <= '0;
            sign_r <= u_sign[0] ^ u_sign[1];
            zero_r <= |u_zero;
            ea_r   <= u_exp[0];
            eb_r   <= u_exp[1];
        end else if (state == S_MUL) begin
            cnt <= cnt + 1'b1;
        end
    end

    fmul_shiftadd #(.SIG_W(SIG_W)) u_sa (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state == S_MUL),
        .mcand   (u_sig[0]),
        .mplier  (u_sig[1]),
        .prod_hi (prod_hi)
    );

    fmul_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pk (
        .prod_hi (prod_hi),
        .ea      (ea_r),
        .eb      (eb_r),
        .sign    (sign_r),
        .zero    (zero_r),
        .word    (pk_word),
        .ovf     (pk_ovf),
        .unf     (pk_unf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            out_valid <= (state == S_PACK);
            if (state == S_PACK) begin
                result <= pk_word;
                ovf    <= pk_ovf;
                unf    <= pk_unf;
            end
        end
    end
endmodule

// File: rtl/fmul_checker.sv
module fmul_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              ovf,
    input logic              unf
);
    // R2: strobe lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: overflow flag goes with a signed infinity word
    a_r8_ovf_infinity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R9: underflow flag goes with a flushed magnitude
    a_r9_unf_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf) |-> (result[WORD_W-2:0] == '0));

    // R8 and R9 cannot both report on one result
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    // R11: outputs hold while no strobe
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(result) && $stable(ovf) && $stable(unf)));
endmodule

bind fmul_core fmul_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/sim_fmul_core.sv
module sim_fmul_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf, unf;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fmul_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
    );

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: returns {ovf, unf, word}
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
        longint ma, mb, p, e;
        logic s, top;
        logic [22:0] f;
        if (a[30:23] == 0 || b[30:23] == 0) return 34'h0;
        s  = a[31] ^ b[31];
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        p  = ma * mb;
        top = p[47];
        e  = longint'(a[30:23]) + longint'(b[30:23]) - 127 + (top ? 1 : 0);
        f  = top ? p[46:24] : p[45:23];
        if (e >= 255) return {2'b10, s, 8'hFF, 23'h0};
        if (e <= 0)   return {2'b01, s, 31'h0};
        return {2'b00, s, e[7:0], f};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [33:0] got, output int lat);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        got = {ovf, unf, result};
    endtask

    task automatic judge(input logic [31:0] a, input logic [31:0] b);
        logic [33:0] got, exp;
        int lat;
        run_op(a, b, got, lat);
        exp = model(a, b);
        check("R2 latency", 34'(lat), 34'd25);
        if (a[30:23] == 0 || b[30:23] == 0) check("R4 zero operand", got, exp);
        else if (exp[33])                   check("R8 overflow", got, exp);
        else if (exp[32])                   check("R9 underflow", got, exp);
        else                                check("R5 R7 product", got, exp);
        if (exp[31:0] != 0) check("R3 sign", 34'(got[31]), 34'(a[31] ^ b[31]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [33:0] got;
        int lat;
        int exps [12] = '{0, 1, 2, 63, 64, 100, 126, 127, 128, 190, 191, 254};
        logic [22:0] fr [4] = '{23'h0, 23'h400000, 23'h7FFFFF, 23'h2AAAAA};

        repeat (3) @(negedge clk);
        check("R1 reset", {ovf, unf, result}, 34'h0);
        check("R1 reset valid", 34'(out_valid), 34'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {out_valid, ovf, unf, result[30:0]}, 34'h0);

        // R5 worked example
        run_op(32'hC1900000, 32'h41180000, got, lat);
        check("R5 example", got, {2'b00, 32'hC32B0000});
        // R6 normalisation shift
        run_op(32'h3FC00000, 32'h3FC00000, got, lat);
        check("R6 normalise", got, {2'b00, 32'h40100000});
        // R8 boundary pushed over by normalisation
        run_op({1'b1, 8'd190, 23'h400000}, {1'b0, 8'd191, 23'h400000}, got, lat);
        check("R8 shift overflow", got, {2'b10, 1'b1, 8'hFF, 23'h0});
        run_op({1'b0, 8'd190, 23'h0}, {1'b0, 8'd191, 23'h0}, got, lat);
        check("R7 top exponent", got, {2'b00, 1'b0, 8'd254, 23'h0});
        // R9 boundary rescued by normalisation
        run_op({1'b0, 8'd63, 23'h400000}, {1'b0, 8'd64, 23'h400000}, got, lat);
        check("R9 rescued", got, {2'b00, 1'b0, 8'd1, 23'h100000});
        run_op({1'b0, 8'd63, 23'h0}, {1'b1, 8'd64, 23'h0}, got, lat);
        check("R9 flush", got, {2'b01, 1'b1, 31'h0});
        // R4 zero with the other operand large
        run_op(32'h00000000, 32'hFF7FFFFF, got, lat);
        check("R4 zero", got, 34'h0);

        // R10: strobe during MUL is ignored
        @(negedge clk);
        in_valid = 1'b1; op_a = 32'h40000000; op_b = 32'h40400000;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        in_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 6;
        while (!out_valid && lat < 60) begin @(negedge clk); lat++; end
        check("R10 first result kept", {ovf, unf, result}, {2'b00, 32'h40C00000});
        check("R10 latency", 34'(lat), 34'd25);
        begin
            int extra = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (out_valid) extra++;
                if (k == 20) check("R11 hold", {ovf, unf, result}, {2'b00, 32'h40C00000});
            end
            check("R10 no extra pulse", 34'(extra), 34'd0);
        end

        // Sweep over exponent pairs and fraction patterns
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int k = 0; k < 4; k++)
                    judge({1'(i ^ j), 8'(exps[i]), fr[k]},
                          {1'(k), 8'(exps[j]), fr[(k + j) % 4]});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule